// File: doc/BRIEF.md
# Idle Bus Escalating Watchdog

This block watches a single-bit bus activity strobe and measures how long the bus has stayed quiet. It counts clock cycles in windows of a fixed length, set by a parameter. Each window that passes with no strobe produces a one-cycle warning. A 2-bit counter shows how many warnings have been issued since the last activity.

After the third warning the block moves into a final alarm state and holds it. While the alarm is set, further bus activity is ignored. Only a service input takes the block back to normal idle counting. The alarm cannot clear itself, so a stalled bus master always reaches the handling logic even if the bus wakes up again before anyone responds.

Top module: `idle_escalation_wdog`

## Requirements
- R1: While `rst` is high, `warn_pulse_o`, `warn_count_o` and `alarm_o` are all 0, and the idle count restarts from zero.
- R2: After reset, or after any restart, `IDLE_CYCLES` consecutive idle clock edges cause `warn_pulse_o` to go high and `warn_count_o` to increase by one. Both appear after the last of those edges.
- R3: A cycle with `bus_active_i` high restarts the idle window. The next warning needs `IDLE_CYCLES` further idle edges.
- R4: Outside the alarm state, a cycle with `bus_active_i` high sets `warn_count_o` to 0 on the following edge.
- R5: `warn_pulse_o` is high for exactly one cycle for each warning.
- R6: The third warning sets `alarm_o` to 1 and `warn_count_o` to 3 (binary 11) on the same edge as its pulse.
- R7: While `alarm_o` is 1 and `service_i` is low, `bus_active_i` has no effect:
  - `alarm_o` stays 1.
  - `warn_count_o` stays 3.
  - No warning pulse is issued.
- R8: A cycle with `service_i` high takes priority over `bus_active_i`. On the next edge, `alarm_o` and `warn_count_o` become 0 and a fresh idle window starts. The next warning then follows after `IDLE_CYCLES` idle edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_active_i | input | 1 | Bus activity strobe, one per active cycle |
| service_i | input | 1 | Alarm handling acknowledge; clears alarm and counts |
| warn_pulse_o | output | 1 | One-cycle pulse per expired idle window |
| warn_count_o | output | 2 | Warnings issued since last activity or service |
| alarm_o | output | 1 | Sticky final alarm |

## Verification
A stale or miscounted idle counter shows up as a warning pulse that comes one or more cycles too early or too late. The bench compares the outputs with a reference every cycle, so that error is caught within one idle window. A wrong stage state shows at the ports within one cycle:
- an alarm that drops while `service_i` is low;
- a warning count that does not clear after a strobe;
- a pulse that lasts two cycles.

Random runs with rare strobes and service requests cover escalation that is broken off partway, then restarted, many times.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned WARN_STAGES = 3;
    localparam int unsigned WARN_W      = 2;

    typedef logic [WARN_W-1:0] warn_cnt_t;

    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_ALARM = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic      pulse;
        warn_cnt_t count;
        wd_state_e state;
    } wd_status_t;

    function automatic warn_cnt_t count_step(input warn_cnt_t c);
        return c + warn_cnt_t'(1);
    endfunction

    function automatic logic is_last_stage(input warn_cnt_t c);
        return c == warn_cnt_t'(WARN_STAGES - 1);
    endfunction

endpackage

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int unsigned IDLE_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic restart_i,
    output logic expire_o
);
    localparam int unsigned CW = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_comb expire_o = run_i && !restart_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // R3: the idle window count never passes its last value
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R3: a restart empties the window on the next edge
    p_restart_r3: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (cnt_q == '0));

endmodule

// File: rtl/warn_stage.sv
module warn_stage
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       act_i,
    input  logic       svc_i,
    input  logic       expire_i,
    output wd_status_t status_o,
    output logic       run_o
);
    wd_state_e state_q;
    warn_cnt_t count_q;
    logic      pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WATCH;
            count_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (svc_i) begin
                state_q <= ST_WATCH;
                count_q <= '0;
            end else if (state_q == ST_ALARM) begin
                state_q <= ST_ALARM;
            end else if (act_i) begin
                count_q <= '0;
            end else if (expire_i) begin
                pulse_q <= 1'b1;
                count_q <= count_step(count_q);
                if (is_last_stage(count_q)) begin
                    state_q <= ST_ALARM;
                end
            end
        end
    end

    always_comb begin
        status_o.pulse = pulse_q;
        status_o.count = count_q;
        status_o.state = state_q;
        run_o          = (state_q == ST_WATCH);
    end

    // R5: warnings never last two cycles
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    // R6: alarm always reports three warnings
    p_alarm_count_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ALARM) |-> (count_q == warn_cnt_t'(WARN_STAGES)));

    // R7: only service leaves the alarm
    p_alarm_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_ALARM) && !svc_i) |=> ((state_q == ST_ALARM) && !pulse_q));

    // R4: activity outside the alarm clears the warning count
    p_act_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (act_i && !svc_i && (state_q == ST_WATCH)) |=> (count_q == '0));

    // R8: service returns to watching with no warnings
    p_service_r8: assert property (@(posedge clk) disable iff (rst)
        svc_i |=> ((state_q == ST_WATCH) && (count_q == '0) && !pulse_q));

endmodule

// File: rtl/idle_escalation_wdog.sv
module idle_escalation_wdog
    import wdog_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_active_i,
    input  logic       service_i,
    output logic       warn_pulse_o,
    output logic [1:0] warn_count_o,
    output logic       alarm_o
);
    logic       expire;
    logic       run;
    wd_status_t status;

    idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run),
        .restart_i (bus_active_i || service_i),
        .expire_o  (expire)
    );

    warn_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .act_i    (bus_active_i),
        .svc_i    (service_i),
        .expire_i (expire),
        .status_o (status),
        .run_o    (run)
    );

    always_comb begin
        warn_pulse_o = status.pulse;
        warn_count_o = status.count;
        alarm_o      = (status.state == ST_ALARM);
    end

    // R2: a warning only ever follows an expired window
    p_pulse_cause_r2: assert property (@(posedge clk) disable iff (rst)
        warn_pulse_o |-> $past(expire));

endmodule

// File: tb/idle_escalation_wdog_tb.sv
module idle_escalation_wdog_tb;
    localparam int unsigned N = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       act = 1'b0;
    logic       svc = 1'b0;
    logic       warn;
    logic [1:0] cnt;
    logic       alarm;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit model_on = 0;

    int   m_idle  = 0;
    int   m_cnt   = 0;
    logic m_alarm = 0;
    logic m_pulse = 0;

    always #2 clk = ~clk;

    idle_escalation_wdog #(.IDLE_CYCLES(N)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_active_i (act),
        .service_i    (svc),
        .warn_pulse_o (warn),
        .warn_count_o (cnt),
        .alarm_o      (alarm)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, actual, expected, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_idle = 0; m_cnt = 0; m_alarm = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            if (svc) begin
                m_idle = 0; m_cnt = 0; m_alarm = 0;
            end else if (m_alarm) begin
                m_idle = 0;
            end else if (act) begin
                m_idle = 0; m_cnt = 0;
            end else if (m_idle == N - 1) begin
                m_idle = 0; m_pulse = 1; m_cnt = m_cnt + 1;
                if (m_cnt == 3) m_alarm = 1;
            end else begin
                m_idle = m_idle + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && !rst) begin
            check("R5 pulse", int'(warn), int'(m_pulse));
            check("R6 count", int'(cnt), m_cnt);
            check("R7 alarm", int'(alarm), int'(m_alarm));
        end
    end

    task automatic idle(input int k);
        act = 1'b0;
        repeat (k) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 warn", int'(warn), 0);
        check("R1 count", int'(cnt), 0);
        check("R1 alarm", int'(alarm), 0);
        rst = 1'b0;
        model_on = 1;

        idle(N - 1);
        check("R2 early", int'(warn), 0);
        idle(1);
        check("R2 pulse", int'(warn), 1);
        check("R2 count", int'(cnt), 1);
        idle(1);
        check("R5 drop", int'(warn), 0);

        idle(N / 2);
        act = 1'b1; @(negedge clk); act = 1'b0;
        check("R4 clear", int'(cnt), 0);
        idle(N - 1);
        check("R3 restart", int'(warn), 0);
        idle(1);
        check("R3 window", int'(warn), 1);

        idle(2 * N);
        check("R6 alarm", int'(alarm), 1);
        check("R6 count3", int'(cnt), 3);
        check("R6 pulse", int'(warn), 1);

        act = 1'b1;
        for (int i = 0; i < 3 * N; i++) @(negedge clk);
        check("R7 held", int'(alarm), 1);
        check("R7 count", int'(cnt), 3);
        idle(3 * N);
        check("R7 idle", int'(alarm), 1);

        act = 1'b1; svc = 1'b1; @(negedge clk);
        act = 1'b0; svc = 1'b0;
        check("R8 alarm", int'(alarm), 0);
        check("R8 count", int'(cnt), 0);
        idle(N - 1);
        check("R8 wait", int'(warn), 0);
        idle(1);
        check("R8 fresh", int'(warn), 1);

        for (int i = 0; i < 4000; i++) begin
            act = (($urandom % 100) < 3);
            svc = (($urandom % 100) < 2);
            @(negedge clk);
        end
        act = 1'b0; svc = 1'b0;

        rst = 1'b1; @(negedge clk);
        check("R1 rerst", int'(cnt) + int'(alarm) + int'(warn), 0);
        finish_run();
    end

    initial begin
        wait (cycles > 100000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        finish_run();
    end

endmodule